// File: doc/BRIEF.md
# Phase-Switching Programmable Frequency Divider

This block is a cycle-accurate digital model of a programmable clock divider. It divides its input clock by any integer from 220 to 224. The input clock drives a prescaler that counts by four. The prescaler produces four square waves at one quarter of the input rate, and each wave rises one input cycle after the one before it. A four-way multiplexer passes one of these phases to a fixed chain of counter stages. Without switching, the chain divides the prescaler rate by 54, so the base ratio is 216.

To reach higher ratios, the block moves the multiplexer to the next lagging phase a set number of times in each output period. Each move stretches one prescaler cycle from four input cycles to five. A pulse generator issues the moves at evenly spaced positions of the chain count. A two-bit state counter holds the selected phase, and a decoder turns it into a one-hot multiplexer select. A move is applied only in the input cycle where the current phase and the next phase are both high, so the muxed clock never sees a spurious edge.

A three-bit code selects the ratio. The block samples the code only at output period boundaries.

Top module: `phase_switch_divider`

## Requirements
- R1: While reset is held, `div_out` and `period_mark` are 0. No `period_mark` appears within the first 150 input cycles after reset is released.
- R2: For code values 0 to 4, consecutive `period_mark` pulses are 220 + code input cycles apart.
- R3: For code values 5, 6 and 7, consecutive `period_mark` pulses are 224 input cycles apart.
- R4: A code change is taken at the next output period boundary. The period already running completes with the ratio of the previous code.
- R5: `period_mark` is high for exactly one input cycle and rises on the same edge as `div_out`. `div_out` is low in the cycle before it.
- R6: The four prescaler phases have equal shape, and each one equals the previous phase delayed by one input cycle.
- R7: The phase select is one-hot and only ever steps to the lagging neighbour. The step is taken only while both the old phase and the new phase are high, so the muxed clock shows no extra edge.
- R8: Each output period contains exactly min(4 + code, 8) phase steps. Consecutive rising edges of the muxed clock are 4 or 5 input cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | High-rate input clock |
| rst | input | 1 | Synchronous reset, active high |
| mod_sel | input | 3 | Ratio code: 220 + code, with codes above 4 clamped to 224 |
| div_out | output | 1 | Divided clock; high for the first half of the chain count |
| period_mark | output | 1 | One-cycle pulse at the start of each output period |

## Verification
The boundary edge updates three things together: `period_mark`, the rise of `div_out` and the latched code. A code driven mid-period therefore first shows in the period after the next mark. The period in flight must still measure with the old ratio. The driver changes the code 50 cycles after a mark and pushes each period's expected length at the mark that opens it. The monitor counts input cycles on falling edges between marks and pops one expectation per closed period. Phase relations and the step timing are checked on every cycle by the properties inside the design.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;
   localparam int QUAD = 4;
   typedef logic [1:0] quad_idx_t;

   // level of phase k for prescaler count q: high for two of four counts
   function automatic logic phase_level(input quad_idx_t q, input quad_idx_t k);
      quad_idx_t d;
      d = q - k;
      return (d < 2'd2);
   endfunction
endpackage

// File: rtl/pdiv_quad_prescaler.sv
module pdiv_quad_prescaler
   import pdiv_pkg::*;
(
   input  logic            clk,
   input  logic            rst,
   output logic [QUAD-1:0] phase
);
   quad_idx_t q_cnt;

   always_ff @(posedge clk) begin
      if (rst) q_cnt <= '0;
      else     q_cnt <= q_cnt + 2'd1;
   end

   always_comb begin
      for (int k = 0; k < QUAD; k++) phase[k] = phase_level(q_cnt, quad_idx_t'(k));
   end

   logic armed_q;
   always_ff @(posedge clk) armed_q <= !rst;

   genvar g;
   generate
      for (g = 1; g < QUAD; g++) begin : g_lag_chk
         assert_phase_lag_R6: assert property (@(posedge clk) disable iff (rst || !armed_q)
            phase[g] == $past(phase[g-1]));
      end
   endgenerate
endmodule

// File: rtl/pdiv_phase_select.sv
module pdiv_phase_select
   import pdiv_pkg::*;
(
   input  logic            clk,
   input  logic            rst,
   input  logic [QUAD-1:0] phase,
   input  logic            step_req,
   output logic            tick,
   output logic            switched
);
   quad_idx_t       sel_idx;
   quad_idx_t       nxt_idx;
   logic [QUAD-1:0] sel_oh;
   logic            pend_q;
   logic            mux_out;
   logic            mux_d;
   logic            window;

   // decoder: state -> one-hot mux control
   always_comb begin
      for (int k = 0; k < QUAD; k++) sel_oh[k] = (sel_idx == quad_idx_t'(k));
   end

   assign nxt_idx  = sel_idx + 2'd1;
   assign mux_out  = |(phase & sel_oh);
   assign tick     = mux_out & ~mux_d;
   // retiming window: current and lagging phase both high
   assign window   = phase[sel_idx] & phase[nxt_idx];
   assign switched = pend_q & window;

   always_ff @(posedge clk) begin
      if (rst) begin
         sel_idx <= '0;
         pend_q  <= 1'b0;
         mux_d   <= 1'b0;
      end else begin
         mux_d  <= mux_out;
         pend_q <= (pend_q & ~window) | step_req;
         if (switched) sel_idx <= nxt_idx;
      end
   end

   // gap between muxed rising edges
   logic [2:0] gap_q;
   logic       seen_q;
   always_ff @(posedge clk) begin
      if (rst) begin
         gap_q  <= '0;
         seen_q <= 1'b0;
      end else if (tick) begin
         gap_q  <= '0;
         seen_q <= 1'b1;
      end else if (gap_q != 3'd7) begin
         gap_q  <= gap_q + 3'd1;
      end
   end

   assert_sel_onehot_R7: assert property (@(posedge clk) disable iff (rst)
      $countones(sel_oh) == 1);
   assert_lag_step_R7: assert property (@(posedge clk) disable iff (rst)
      (sel_idx != $past(sel_idx)) |-> (sel_idx == $past(sel_idx) + 2'd1));
   assert_no_glitch_R7: assert property (@(posedge clk) disable iff (rst)
      (sel_idx != $past(sel_idx)) |-> (mux_out && $past(mux_out)));
   assert_tick_gap_R8: assert property (@(posedge clk) disable iff (rst)
      (tick && seen_q) |-> (gap_q == 3'd3 || gap_q == 3'd4));
endmodule

// File: rtl/pdiv_stage_chain.sv
module pdiv_stage_chain #(
   parameter int STAGES            = 4,
   parameter int STAGE_MOD[STAGES] = '{2, 3, 3, 3},
   parameter int CNT_W             = 2,
   parameter int IDX_W             = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   output logic [IDX_W-1:0] idx,
   output logic             at_last
);
   logic [CNT_W-1:0] cnt_q [STAGES];
   logic [STAGES:0]  carry;
   logic [STAGES:0]  term;

   assign carry[0] = tick;
   assign term[0]  = 1'b1;

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         localparam logic [CNT_W-1:0] LAST = CNT_W'(STAGE_MOD[g] - 1);
         initial begin
            assert (STAGE_MOD[g] >= 2 && STAGE_MOD[g] <= (1 << CNT_W))
               else $error("stage modulus out of range");
         end
         assign term[g+1]  = term[g] & (cnt_q[g] == LAST);
         assign carry[g+1] = carry[g] & (cnt_q[g] == LAST);
         always_ff @(posedge clk) begin
            if (rst)           cnt_q[g] <= '0;
            else if (carry[g]) cnt_q[g] <= (cnt_q[g] == LAST) ? '0 : cnt_q[g] + 1'b1;
         end
      end
   endgenerate

   always_comb begin
      int acc;
      int w;
      acc = 0;
      w   = 1;
      for (int i = 0; i < STAGES; i++) begin
         acc = acc + int'(cnt_q[i]) * w;
         w   = w * STAGE_MOD[i];
      end
      idx = IDX_W'(acc);
   end

   assign at_last = term[STAGES];
endmodule

// File: rtl/phase_switch_divider.sv
module phase_switch_divider
   import pdiv_pkg::*;
#(
   parameter int CODE_W            = 3,
   parameter int STAGES            = 4,
   parameter int STAGE_MOD[STAGES] = '{2, 3, 3, 3},
   parameter int SPACING           = 6,
   parameter int MIN_SW            = 4,
   parameter int MAX_SW            = 8
) (
   input  logic              clk_in,
   input  logic              rst,
   input  logic [CODE_W-1:0] mod_sel,
   output logic              div_out,
   output logic              period_mark
);
   function automatic int chain_ticks();
      int p;
      p = 1;
      for (int i = 0; i < STAGES; i++) p = p * STAGE_MOD[i];
      return p;
   endfunction

   localparam int TICKS = chain_ticks();
   localparam int HALF  = TICKS / 2;
   localparam int IDX_W = $clog2(TICKS);
   localparam int SW_W  = $clog2(MAX_SW + 1);

   initial begin
      assert (MAX_SW * SPACING <= TICKS) else $error("switch slots exceed chain count");
      assert (MIN_SW + (1 << CODE_W) - 1 >= MAX_SW) else $error("code range too narrow");
      assert (MIN_SW <= MAX_SW) else $error("switch bounds inverted");
   end

   logic [QUAD-1:0]   phase;
   logic              tick;
   logic              switched;
   logic              step_req;
   logic [IDX_W-1:0]  idx;
   logic              at_last;
   logic              boundary;
   logic [CODE_W-1:0] code_q;
   logic [SW_W-1:0]   nsw;
   logic              div_q;
   logic              mark_q;

   pdiv_quad_prescaler u_pre (
      .clk   (clk_in),
      .rst   (rst),
      .phase (phase)
   );

   pdiv_phase_select u_sel (
      .clk      (clk_in),
      .rst      (rst),
      .phase    (phase),
      .step_req (step_req),
      .tick     (tick),
      .switched (switched)
   );

   pdiv_stage_chain #(
      .STAGES    (STAGES),
      .STAGE_MOD (STAGE_MOD),
      .CNT_W     (2),
      .IDX_W     (IDX_W)
   ) u_chain (
      .clk     (clk_in),
      .rst     (rst),
      .tick    (tick),
      .idx     (idx),
      .at_last (at_last)
   );

   assign boundary = tick & at_last;

   always_comb begin
      int want;
      want = MIN_SW + int'(code_q);
      if (want > MAX_SW) want = MAX_SW;
      nsw = SW_W'(want);
   end

   // pulse generator: one request at the end of each slot below nsw
   assign step_req = tick
                   && ((int'(idx) % SPACING) == SPACING - 1)
                   && ((int'(idx) / SPACING) < int'(nsw));

   always_ff @(posedge clk_in) begin
      if (rst) begin
         code_q <= mod_sel;
         div_q  <= 1'b0;
         mark_q <= 1'b0;
      end else begin
         mark_q <= boundary;
         if (boundary) code_q <= mod_sel;
         if (tick) div_q <= boundary ? 1'b1 : ((int'(idx) + 1) < HALF);
      end
   end

   assign div_out     = div_q;
   assign period_mark = mark_q;

   // switches counted per output period
   logic [SW_W-1:0] sw_cnt;
   always_ff @(posedge clk_in) begin
      if (rst)           sw_cnt <= '0;
      else if (boundary) sw_cnt <= '0;
      else if (switched) sw_cnt <= sw_cnt + 1'b1;
   end

   assert_switch_count_R8: assert property (@(posedge clk_in) disable iff (rst)
      boundary |-> (sw_cnt == nsw));
   assert_mark_pulse_R5: assert property (@(posedge clk_in) disable iff (rst)
      period_mark |=> !period_mark);
   assert_mark_with_div_R5: assert property (@(posedge clk_in) disable iff (rst)
      $rose(period_mark) |-> $rose(div_out));
endmodule

// File: tb/phase_switch_divider_bench.sv
module phase_switch_divider_bench;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [2:0] mod_sel = 3'd0;
   logic       div_out;
   logic       period_mark;

   phase_switch_divider u_phase_switch_divider (
      .clk_in      (clk),
      .rst         (rst),
      .mod_sel     (mod_sel),
      .div_out     (div_out),
      .period_mark (period_mark)
   );

   always #4 clk = ~clk;

   typedef struct {
      int    len;
      string tag;
   } item_t;

   item_t sb[$];
   int    checks = 0;
   int    errors = 0;
   int    mark_count = 0;
   bit    done = 1'b0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int exp_len(input int c);
      return 220 + ((c > 4) ? 4 : c);
   endfunction

   function automatic string tag_of(input int c);
      return (c > 4) ? "R3/R8" : "R2/R6/R7/R8";
   endfunction

   task automatic report();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   // monitor: period length and mark shape
   int cyc = 0;
   int last_mark = 0;
   bit have_prev = 1'b0;
   bit prev_mark = 1'b0;
   bit prev_div  = 1'b0;
   always @(negedge clk) begin
      cyc++;
      if (!rst && period_mark) begin
         mark_count++;
         check(div_out == 1'b1 && prev_div == 1'b0, "R5 div_out rising at mark",
               {prev_div, div_out}, 1);
         check(prev_mark == 1'b0, "R5 mark single cycle", int'(prev_mark), 0);
         if (have_prev) begin
            if (sb.size() == 0) begin
               check(1'b0, "R2 scoreboard empty", cyc - last_mark, 0);
            end else begin
               item_t it;
               it = sb.pop_front();
               check(cyc - last_mark == it.len, it.tag, cyc - last_mark, it.len);
            end
         end
         last_mark = cyc;
         have_prev = 1'b1;
      end
      prev_mark = period_mark;
      prev_div  = div_out;
   end

   task automatic wait_mark();
      do @(negedge clk); while (period_mark !== 1'b1);
   endtask

   task automatic push(input int len, input string tag);
      item_t it;
      it.len = len;
      it.tag = tag;
      sb.push_back(it);
   endtask

   initial begin
      int codes[9] = '{1, 2, 3, 4, 5, 6, 7, 0, 3};
      int cur;
      cur = 0;
      repeat (5) @(negedge clk);
      check(div_out == 1'b0, "R1 div_out in reset", int'(div_out), 0);
      check(period_mark == 1'b0, "R1 mark in reset", int'(period_mark), 0);
      rst = 1'b0;
      repeat (150) @(negedge clk);
      check(mark_count == 0, "R1 no early mark", mark_count, 0);
      for (int s = 0; s < 9; s++) begin
         wait_mark();
         push(exp_len(cur), (cur != codes[s]) ? "R4 old ratio kept" : tag_of(cur));
         repeat (50) @(negedge clk);
         mod_sel = 3'(codes[s]);
         cur = codes[s];
         wait_mark();
         push(exp_len(cur), tag_of(cur));
      end
      wait_mark();
      repeat (3) @(negedge clk);
      check(sb.size() == 0, "R2 all periods seen", sb.size(), 0);
      done = 1'b1;
      report();
      $finish;
   end

   initial begin
      repeat (60000) @(negedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         report();
         $finish;
      end
   end
endmodule